// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers the maskable interrupt events of a chip's peripherals: four general port inputs, two key inputs, DMA end-of-transfer events, the compare and underflow events of the timers, and the receive and transmit events of two serial channels. Every source has its own pending flag, latched according to that source's trigger style. A per-source enable mask gates which flags may raise a request. Among the enabled pending flags a fixed-priority selector picks one, and the block presents the CPU with a request line, the vector number of the winner and the address of its vector table entry. That address is a programmable, 1 KB aligned table base plus four times the vector number.

Many sources also own a channel on an intelligent DMA engine. When software sets a source's DMA-routing bit, a pending flag on that source no longer interrupts the CPU. Instead it raises a single-cycle request on its DMA channel, and the flag is cleared when that channel acknowledges. Software programs the block through a narrow write-only port. One write selects one of five registers: write-one flag clear, enable mask, DMA-routing mask, trigger configuration and table base.

The source index used on all mask-shaped ports runs from 0 (highest priority) to 32 (lowest priority). The vector numbers run from 16 to 62, and the unused numbers in that range are skipped.

Top module: `vpic_top`

## Requirements
- R1: After reset, irq_o is 0, irq_vec_o is 0, irq_addr_o is 0 and dma_req_o is all zero. All enables, routing bits and trigger settings are 0, and the table base is 0. While irq_o is 0, irq_vec_o and irq_addr_o read 0.
- R2: Source index i has a fixed vector number. Indices 0..10 map to 16..26. Indices 11..22 map to pairs 30,31 / 34,35 / 38,39 / 42,43 / 46,47 / 50,51. Indices 23..29 map to 52..58, and indices 30..32 map to 60..62. Vectors 27-29, 32, 33, 36, 37, 40, 41, 44, 45, 48, 49 and 59 never appear on irq_vec_o.
- R3: irq_addr_o equals the table base plus 4 × irq_vec_o. A write with reg_sel_i=4 loads reg_wdata_i[21:0] into base bits [31:10]. The low 10 bits of the base are always zero.
- R4: Priority is fixed: the lowest source index (lowest vector) wins among the CPU-routed pending sources. Within each timer, the compare-B source (even offset, lower vector) beats compare A.
- R5: An edge-triggered flag sets on the active edge of its input and stays set until a write with reg_sel_i=0 has a 1 in its bit. If a new active edge and that clear occur in the same cycle, the flag stays set. Sources with index 6 and above always trigger on rising edges.
- R6: Ports 0..3 (indices 0..3) use trigger configuration bit [p] for mode (1 = level) and bit [4+p] for polarity (1 = active low / falling edge). In level mode the flag follows the input one cycle later, and clear writes have no effect on it.
- R7: Key inputs (indices 4 and 5) are edge-triggered only. Trigger configuration bits [8] and [9] select falling (1) or rising (0) edges. An edge of the opposite direction sets nothing.
- R8: The enable mask is written with reg_sel_i=1 (bit i = source i). A disabled source does not raise irq_o, but its flag still latches and raises irq_o as soon as it is enabled. The trigger configuration is written with reg_sel_i=3.
- R9: The routing mask is written with reg_sel_i=2. For an enabled, routed source that has a DMA channel c, a pending flag drives dma_req_o[c-1] high for exactly one cycle and does not raise irq_o. The flag is cleared when dma_ack_i[c-1] is high. Channels: indices 0-3 use 1-4, indices 6 and 7 use 5 and 6, indices 11-26 use 7-22, indices 28 and 29 use 23 and 24, and indices 31 and 32 use 25 and 26.
- R10: The routing bit is ignored for sources without a DMA channel (indices 4, 5, 8, 9, 10, 27, 30). Those sources still interrupt the CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 33 | Raw interrupt inputs, bit i = source index i |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select: 0 clear, 1 enable, 2 routing, 3 trigger, 4 base |
| reg_wdata_i | input | 33 | Write data |
| dma_ack_i | input | 26 | DMA acknowledge, bit c-1 = channel c |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | 6 | Vector number of the selected source |
| irq_addr_o | output | 32 | Vector table entry address |
| dma_req_o | output | 26 | Single-cycle DMA trigger, bit c-1 = channel c |

## Verification
Two operations can act on one edge-style flag in the same clock cycle: software writing a 1 to clear it, and the input producing a fresh active edge. The bench first latches port 0. It then drives the input high in exactly the cycle in which the clear write is on the port. Afterwards it expects irq_o to remain high with vector 16, because a lost event would be the worse failure. The same rule covers a DMA acknowledge that meets a new edge, and the checker watches a source with no DMA channel to confirm that its flag never drops without a clear.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  localparam int NUM_SRC   = 33;
  localparam int NUM_CH    = 26;
  localparam int N_PORT    = 4;
  localparam int N_KEY     = 2;
  localparam int TRIG_W    = 2 * N_PORT + N_KEY;
  localparam int VEC_W     = 6;
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int SEL_W     = 3;

  typedef enum logic [SEL_W-1:0] {
    REG_CLR   = 3'd0,
    REG_EN    = 3'd1,
    REG_ROUTE = 3'd2,
    REG_TRIG  = 3'd3,
    REG_BASE  = 3'd4
  } reg_sel_e;

  // Vector number of a source index; the gaps in the vector range are skipped.
  function automatic logic [VEC_W-1:0] src_vector(int idx);
    int v;
    if (idx <= 10)      v = 16 + idx;
    else if (idx <= 22) v = 30 + 4 * ((idx - 11) / 2) + ((idx - 11) % 2);
    else if (idx <= 29) v = 52 + (idx - 23);
    else                v = 60 + (idx - 30);
    return VEC_W'(v);
  endfunction

  // DMA channel of a source index, 0 when the source has none.
  function automatic int src_channel(int idx);
    if (idx <= 3)                    return idx + 1;
    if (idx == 6 || idx == 7)        return idx - 1;
    if (idx >= 11 && idx <= 26)      return idx - 4;
    if (idx == 28 || idx == 29)      return idx - 5;
    if (idx == 31 || idx == 32)      return idx - 6;
    return 0;
  endfunction

  // Table entry address: base plus four bytes per vector.
  function automatic logic [31:0] entry_addr(logic [31:0] base, logic [VEC_W-1:0] vec);
    return base + {24'd0, vec, 2'b00};
  endfunction

endpackage

// File: rtl/vpic_src_latch.sv
module vpic_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic level_mode_i,
  input  logic pol_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic flag_o
);

  logic act;
  logic act_prev_q;
  logic rise;
  logic flag_q;

  assign act  = req_i ^ pol_i;
  assign rise = act & ~act_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_prev_q <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      act_prev_q <= act;
      if (level_mode_i) flag_q <= act;
      else              flag_q <= (flag_q & ~(clr_i | ack_i)) | rise;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/vpic_regs.sv
module vpic_regs
  import vpic_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BASE_LSB = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [NUM_SRC-1:0]    wdata_i,
  output logic [NUM_SRC-1:0]    clr_mask_o,
  output logic [NUM_SRC-1:0]    en_o,
  output logic [NUM_SRC-1:0]    route_o,
  output logic [TRIG_W-1:0]     trig_o,
  output logic [ADDR_W-1:0]     base_o
);

  localparam int BASE_W = ADDR_W - BASE_LSB;

  reg_sel_e             sel;
  logic [NUM_SRC-1:0]   en_q;
  logic [NUM_SRC-1:0]   route_q;
  logic [TRIG_W-1:0]    trig_q;
  logic [BASE_W-1:0]    base_q;

  assign sel = reg_sel_e'(sel_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      trig_q  <= '0;
      base_q  <= '0;
    end else if (we_i) begin
      case (sel)
        REG_EN:    en_q    <= wdata_i;
        REG_ROUTE: route_q <= wdata_i;
        REG_TRIG:  trig_q  <= wdata_i[TRIG_W-1:0];
        REG_BASE:  base_q  <= wdata_i[BASE_W-1:0];
        default:   ;
      endcase
    end
  end

  assign clr_mask_o = (we_i && sel == REG_CLR) ? wdata_i : '0;
  assign en_o       = en_q;
  assign route_o    = route_q;
  assign trig_o     = trig_q;
  assign base_o     = {base_q, {BASE_LSB{1'b0}}};

endmodule

// File: rtl/vpic_route.sv
module vpic_route
  import vpic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] route_i,
  input  logic [NUM_CH-1:0]  dma_ack_i,
  output logic [NUM_SRC-1:0] cpu_pend_o,
  output logic [NUM_SRC-1:0] ack_src_o,
  output logic [NUM_CH-1:0]  dma_req_o
);

  logic [NUM_SRC-1:0] to_dma;
  logic [NUM_SRC-1:0] fire;
  logic [NUM_SRC-1:0] busy_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_path
    localparam int CH = src_channel(i);
    if (CH != 0) begin : g_dma
      assign to_dma[i]     = route_i[i];
      assign ack_src_o[i]  = dma_ack_i[CH-1];
      assign dma_req_o[CH-1] = fire[i];
    end else begin : g_cpu
      assign to_dma[i]     = 1'b0;
      assign ack_src_o[i]  = 1'b0;
    end
  end

  assign fire       = flag_i & en_i & to_dma & ~busy_q;
  assign cpu_pend_o = flag_i & en_i & ~to_dma;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= (busy_q | fire) & ~ack_src_o & flag_i;
  end

endmodule

// File: rtl/vpic_prio.sv
module vpic_prio
  import vpic_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   sel_o,
  output logic [VEC_W-1:0]   vec_o
);

  always_comb begin
    any_o = 1'b0;
    sel_o = '0;
    vec_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        any_o = 1'b1;
        sel_o = IDX_W'(i);
        vec_o = src_vector(i);
      end
    end
  end

endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BASE_LSB = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [32:0]        src_i,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_sel_i,
  input  logic [32:0]        reg_wdata_i,
  input  logic [25:0]        dma_ack_i,
  output logic               irq_o,
  output logic [5:0]         irq_vec_o,
  output logic [31:0]        irq_addr_o,
  output logic [25:0]        dma_req_o
);

  logic [NUM_SRC-1:0] clr_mask;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] route_q;
  logic [TRIG_W-1:0]  trig_q;
  logic [ADDR_W-1:0]  tbl_base;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] ack_src;
  logic [NUM_SRC-1:0] cpu_pend;
  logic               any_pend;
  logic [IDX_W-1:0]   sel_idx;
  logic [VEC_W-1:0]   sel_vec;

  vpic_regs #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .clr_mask_o (clr_mask),
    .en_o       (en_q),
    .route_o    (route_q),
    .trig_o     (trig_q),
    .base_o     (tbl_base)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic lvl;
    logic pol;
    if (i < N_PORT) begin : g_port
      assign lvl = trig_q[i];
      assign pol = trig_q[N_PORT + i];
    end else if (i < N_PORT + N_KEY) begin : g_key
      assign lvl = 1'b0;
      assign pol = trig_q[2 * N_PORT + (i - N_PORT)];
    end else begin : g_plain
      assign lvl = 1'b0;
      assign pol = 1'b0;
    end
    vpic_src_latch u_latch (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (src_i[i]),
      .level_mode_i (lvl),
      .pol_i        (pol),
      .clr_i        (clr_mask[i]),
      .ack_i        (ack_src[i]),
      .flag_o       (flag_q[i])
    );
  end

  vpic_route u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_i     (flag_q),
    .en_i       (en_q),
    .route_i    (route_q),
    .dma_ack_i  (dma_ack_i),
    .cpu_pend_o (cpu_pend),
    .ack_src_o  (ack_src),
    .dma_req_o  (dma_req_o)
  );

  vpic_prio u_prio (
    .pend_i (cpu_pend),
    .any_o  (any_pend),
    .sel_o  (sel_idx),
    .vec_o  (sel_vec)
  );

  assign irq_o      = any_pend;
  assign irq_vec_o  = sel_vec;
  assign irq_addr_o = any_pend ? entry_addr(tbl_base, sel_vec) : '0;

endmodule

// File: rtl/vpic_chk.sv
module vpic_chk
  import vpic_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               irq_o,
  input logic [5:0]         irq_vec_o,
  input logic [31:0]        irq_addr_o,
  input logic [25:0]        dma_req_o,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] clr_mask,
  input logic [NUM_SRC-1:0] cpu_pend,
  input logic [IDX_W-1:0]   sel_idx,
  input logic [31:0]        tbl_base
);

  // R1
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (irq_vec_o == '0 && irq_addr_o == '0));

  // R2
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_vec_o >= 6'd16 && irq_vec_o <= 6'd62 &&
               !(irq_vec_o inside {6'd27, 6'd28, 6'd29, 6'd32, 6'd33, 6'd36, 6'd37,
                                   6'd40, 6'd41, 6'd44, 6'd45, 6'd48, 6'd49, 6'd59})));

  // R3
  addr_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_addr_o[31:10] == tbl_base[31:10] &&
               irq_addr_o[9:0] == {2'b00, irq_vec_o, 2'b00}));

  // R4
  prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cpu_pend[sel_idx] &&
               (cpu_pend & ((NUM_SRC'(1) << sel_idx) - NUM_SRC'(1))) == '0));

  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[27] && !clr_mask[27]) |=> flag_q[27]);

  // R8
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((flag_q & en_q) != '0));

  // R9
  dma_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_o != '0) |=> ((dma_req_o & $past(dma_req_o)) == '0));

endmodule

bind vpic_top vpic_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_o      (irq_o),
  .irq_vec_o  (irq_vec_o),
  .irq_addr_o (irq_addr_o),
  .dma_req_o  (dma_req_o),
  .flag_q     (flag_q),
  .en_q       (en_q),
  .clr_mask   (clr_mask),
  .cpu_pend   (cpu_pend),
  .sel_idx    (sel_idx),
  .tbl_base   (tbl_base)
);

// File: tb/vpic_top_tb.sv
`timescale 1ns/1ps
module vpic_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [32:0] src_i = '0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [32:0] reg_wdata_i = '0;
  logic [25:0] dma_ack_i = '0;
  logic        irq_o;
  logic [5:0]  irq_vec_o;
  logic [31:0] irq_addr_o;
  logic [25:0] dma_req_o;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  vpic_top u_dut (.*);

  typedef struct packed {
    logic [32:0] mask;
    logic [5:0]  vec;
  } row_t;

  localparam int NROW = 9;
  localparam row_t ROWS [NROW] = '{
    '{33'h1,                    6'd16},
    '{33'h1 << 32,              6'd62},
    '{(33'h1 << 11) | (33'h1 << 12), 6'd30},
    '{33'h1 << 22,              6'd51},
    '{(33'h1 << 23) | (33'h1 << 30), 6'd52},
    '{(33'h1 << 10) | (33'h1 << 29), 6'd26},
    '{33'h1 << 27,              6'd56},
    '{33'h1 << 30,              6'd60},
    '{(33'h1 << 13) | (33'h1 << 32), 6'd34}
  };

  localparam logic [32:0] ALL = {33{1'b1}};

  function automatic bit reserved(int v);
    return v inside {27, 28, 29, 32, 33, 36, 37, 40, 41, 44, 45, 48, 49, 59};
  endfunction

  function automatic int bench_vec(int idx);
    int n = 0;
    for (int v = 16; v <= 62; v++) begin
      if (!reserved(v)) begin
        if (n == idx) return v;
        n++;
      end
    end
    return -1;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] sel, logic [32:0] data);
    @(negedge clk);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = data;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic pulse(logic [32:0] mask);
    @(negedge clk);
    src_i = src_i | mask;
    @(negedge clk);
    src_i = src_i & ~mask;
  endtask

  initial begin
    logic [31:0] base;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 irq", 64'(irq_o), 0);
    chk("R1 vec", 64'(irq_vec_o), 0);
    chk("R1 addr", 64'(irq_addr_o), 0);
    chk("R1 dma", 64'(dma_req_o), 0);
    pulse(33'h1);
    chk("R1 enables off after reset", 64'(irq_o), 0);
    wr(3'd0, ALL);

    // R3 base, table walk for R4 / R2
    wr(3'd1, ALL);
    wr(3'd4, 33'h5);
    base = 32'h5 << 10;
    for (int r = 0; r < NROW; r++) begin
      wr(3'd0, ALL);
      pulse(ROWS[r].mask);
      chk("R4 irq", 64'(irq_o), 1);
      chk("R4 vec", 64'(irq_vec_o), 64'(ROWS[r].vec));
      chk("R3 addr", 64'(irq_addr_o), 64'(base + (32'(ROWS[r].vec) << 2)));
    end
    wr(3'd0, ALL);
    chk("R5 clear all", 64'(irq_o), 0);

    // R2 every source alone
    for (int i = 0; i < 33; i++) begin
      pulse(33'h1 << i);
      chk("R2 vector map", 64'(irq_vec_o), 64'(bench_vec(i)));
      wr(3'd0, 33'h1 << i);
    end

    // R5 hold and set-wins
    pulse(33'h1 << 27);
    repeat (4) tick();
    chk("R5 hold", 64'(irq_vec_o), 56);
    wr(3'd0, 33'h1 << 27);
    chk("R5 cleared", 64'(irq_o), 0);
    pulse(33'h1);
    @(negedge clk);
    src_i[0] = 1'b1; reg_we_i = 1'b1; reg_sel_i = 3'd0; reg_wdata_i = 33'h1;
    @(negedge clk);
    src_i[0] = 1'b0; reg_we_i = 1'b0; reg_wdata_i = '0;
    chk("R5 set wins irq", 64'(irq_o), 1);
    chk("R5 set wins vec", 64'(irq_vec_o), 16);
    wr(3'd0, ALL);

    // R6 level mode, port 1
    wr(3'd3, 33'h2);
    src_i[1] = 1'b1;
    tick();
    chk("R6 level high", 64'(irq_vec_o), 17);
    wr(3'd0, 33'h2);
    chk("R6 clear ignored", 64'(irq_o), 1);
    src_i[1] = 1'b0;
    tick();
    chk("R6 level drop", 64'(irq_o), 0);
    wr(3'd3, 33'h22);
    tick();
    chk("R6 active low", 64'(irq_vec_o), 17);
    src_i[1] = 1'b1;
    tick();
    chk("R6 active low idle", 64'(irq_o), 0);
    src_i[1] = 1'b0;
    wr(3'd3, 33'h0);
    wr(3'd0, ALL);
    chk("R6 restore", 64'(irq_o), 0);

    // R7 key 0 falling edge
    wr(3'd3, 33'h100);
    wr(3'd0, ALL);
    src_i[4] = 1'b1;
    tick(); tick();
    chk("R7 rising ignored", 64'(irq_o), 0);
    src_i[4] = 1'b0;
    tick();
    chk("R7 falling vec", 64'(irq_vec_o), 20);
    wr(3'd0, ALL);
    wr(3'd3, 33'h0);
    wr(3'd0, ALL);

    // R8 enable mask
    wr(3'd1, 33'h0);
    pulse(33'h4);
    chk("R8 masked", 64'(irq_o), 0);
    wr(3'd1, ALL);
    chk("R8 unmasked vec", 64'(irq_vec_o), 18);
    wr(3'd0, ALL);

    // R9 DMA routing on port 0 (channel 1)
    wr(3'd2, 33'h1);
    pulse(33'h1);
    chk("R9 dma pulse", 64'(dma_req_o), 1);
    chk("R9 no irq", 64'(irq_o), 0);
    tick();
    chk("R9 single cycle", 64'(dma_req_o), 0);
    @(negedge clk); dma_ack_i[0] = 1'b1;
    @(negedge clk); dma_ack_i[0] = 1'b0;
    wr(3'd2, 33'h0);
    chk("R9 ack cleared flag", 64'(irq_o), 0);

    // R10 routing ignored for key 0
    wr(3'd2, 33'h10);
    pulse(33'h10);
    chk("R10 irq vec", 64'(irq_vec_o), 20);
    chk("R10 no dma", 64'(dma_req_o), 0);
    wr(3'd0, ALL);
    wr(3'd2, 33'h0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #800000;
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule